// File: doc/BRIEF.md
# Shared RAM Host Grant Arbiter

This block shares a 16-bit single-port RAM between an internal master, which issues one read or write beat per cycle, and an external host processor. The host raises a request and waits for a grant. While it holds the grant it owns the RAM through its own address, data and strobe lines, and the internal master is stalled. Dropping the request returns the RAM to the internal side.

The grant latency has a fixed bound. If the internal master is idle, or between indivisible sequences, the grant follows the request after one cycle. The internal master marks a beat with a lock flag when the beat after it belongs to the same indivisible group, as in a burst or an atomic swap. A locked group may run on while a request waits, but the stall is forced at the latest in the fourth cycle of the request. The stalled beat then stays pending and completes once the host lets go, so no beat is lost or repeated.

The request path to the grant is combinational on release, so the grant falls in the same cycle as the request. A reserved mailbox word in the RAM is mirrored as a flag. Either side can signal the other by writing that word, and the internal side clears it by writing zero.

Top module: `shram_arbiter`

## Requirements
- R1: After reset, host_gnt_o, cpu_stall_o, flag_o and both read data outputs are 0, and every RAM word reads 0.
- R2: A request that is high at an edge where the previous accepted internal beat had cpu_lock_i=0 stalls the internal master in that same cycle, and host_gnt_o is 1 from the next cycle on.
- R3: While the previous accepted beat had cpu_lock_i=1, internal beats keep being accepted during a pending request. host_gnt_o is nevertheless 1 no later than the 4th cycle after the request rose.
- R4: When host_req_i is 0, host_gnt_o is 0 in that same cycle, and cpu_stall_o is 0. An internal beat presented in that cycle is therefore taken at the next edge.
- R5: While host_req_i is 1 with grant held or pending past a lock boundary, cpu_stall_o is 1 and the presented beat is not performed. It completes unchanged once the stall falls, with no beat lost or duplicated.
- R6: With host_gnt_o=1, host_wr_i=1 writes host_wdata_i to host_addr_i at the edge, and host_rd_i=1 returns the word at host_addr_i on host_rdata_o one cycle later.
- R7: Host strobes presented while host_gnt_o is 0 leave the RAM unchanged.
- R8: An accepted internal beat with cpu_we_i=1 writes cpu_wdata_i at cpu_addr_i. With cpu_we_i=0 it returns the addressed word on cpu_rdata_o one cycle later. Read data holds between reads.
- R9: flag_o is 1 exactly when the last word written to address 255 (the mailbox word) was nonzero, updating one cycle after the write, whichever side wrote it.
- R10: A request that is released for at least one edge and raised again is a new request and again obeys the R2 or R3 bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host bus request |
| host_gnt_o | output | 1 | Host bus grant |
| host_addr_i | input | 8 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_rdata_o | output | 16 | Read data to host |
| cpu_req_i | input | 1 | Internal beat valid |
| cpu_we_i | input | 1 | Internal beat is a write |
| cpu_lock_i | input | 1 | Next beat belongs to the same indivisible group |
| cpu_addr_i | input | 8 | Internal word address |
| cpu_wdata_i | input | 16 | Internal write data |
| cpu_stall_o | output | 1 | Internal beat not accepted this cycle |
| cpu_rdata_o | output | 16 | Read data to internal master |
| flag_o | output | 1 | Mailbox word is nonzero |

## Verification
A wrong grant state shows at the ports within one cycle of a request. The grant may come late: past the first cycle with no lock pending, or past the fourth under a lock. It may also stay high in the cycle the request drops. A stall that is lost or comes too early shows up later, as a RAM word that differs from the reference model when it is next read back, or as a burst whose beat count is wrong. A wrong mailbox register shows on flag_o in the cycle after any write to the reserved word.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_CPU, SRC_HOST} src_e;
endpackage

// File: rtl/shram_grant_ctrl.sv
module shram_grant_ctrl #(
  parameter int MAX_WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_req_i,
  input  logic cpu_req_i,
  input  logic cpu_lock_i,
  output logic host_gnt_o,
  output logic cpu_stall_o,
  output logic cpu_beat_o
);
  localparam int WAIT_W = (MAX_WAIT > 2) ? $clog2(MAX_WAIT) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(MAX_WAIT - 1);

  logic              gnt_q;
  logic              lock_q;
  logic [WAIT_W-1:0] wait_q;
  logic              force_stall;

  assign force_stall = (wait_q == WAIT_LIM);
  // release path stays combinational
  assign host_gnt_o  = host_req_i & gnt_q;
  assign cpu_stall_o = host_req_i & (gnt_q | ~lock_q | force_stall);
  assign cpu_beat_o  = cpu_req_i & ~cpu_stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= 1'b0;
      lock_q <= 1'b0;
      wait_q <= '0;
    end else begin
      gnt_q <= host_req_i & (gnt_q | ~cpu_beat_o);
      if (cpu_beat_o) lock_q <= cpu_lock_i;
      if (!host_req_i || gnt_q) wait_q <= '0;
      else if (!force_stall)    wait_q <= wait_q + 1'b1;
    end
  end

  logic [7:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lat_q <= '0;
    else if (!host_req_i || host_gnt_o)   lat_q <= '0;
    else if (lat_q != 8'hFF)              lat_q <= lat_q + 8'd1;
  end

  // R3
  grant_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_gnt_o) |-> (lat_q < 8'(MAX_WAIT)));
  // R2
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_gnt_o && !lock_q) |=> (host_gnt_o || !host_req_i));
  // R5
  no_cpu_beat_in_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> !cpu_beat_o);
  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_req_i) |-> (!host_gnt_o && !cpu_stall_o));
endmodule

// File: rtl/shram_port_mux.sv
module shram_port_mux
  import shram_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter bit FLAG_EN   = 1'b1,
  parameter int FLAG_ADDR = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_gnt_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  input  logic          cpu_beat_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          flag_o
);
  src_e src;

  always_comb begin
    if (host_gnt_i)      src = SRC_HOST;
    else if (cpu_beat_i) src = SRC_CPU;
    else                 src = SRC_NONE;
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = cpu_addr_i;
    mem_wdata_o = cpu_wdata_i;
    unique case (src)
      SRC_HOST: begin
        mem_we_o    = host_wr_i;
        mem_re_o    = host_rd_i;
        mem_addr_o  = host_addr_i;
        mem_wdata_o = host_wdata_i;
      end
      SRC_CPU: begin
        mem_we_o = cpu_we_i;
        mem_re_o = ~cpu_we_i;
      end
      default: ;
    endcase
  end

  generate
    if (FLAG_EN) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else if (mem_we_o && mem_addr_o == AW'(FLAG_ADDR))
          flag_q <= |mem_wdata_o;
      end
      assign flag_o = flag_q;

      // R9
      flag_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && mem_addr_o == AW'(FLAG_ADDR)) |=> (flag_o == ($past(mem_wdata_o) != '0)));
    end else begin : g_noflag
      assign flag_o = 1'b0;
    end
  endgenerate

  // R7
  host_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_gnt_i && !cpu_beat_i) |-> !mem_we_o);
endmodule

// File: rtl/shram_ram.sv
module shram_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (re_i) rdata_q <= mem[addr_i];
      if (we_i) mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = rdata_q;

  // R6 R8
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem[$past(addr_i)] == $past(wdata_i)));
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int MAX_WAIT  = 4,
  parameter bit FLAG_EN   = 1'b1,
  parameter int FLAG_ADDR = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  output logic          host_gnt_o,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_lock_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_stall_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          flag_o
);
  logic          cpu_beat;
  logic          mem_we;
  logic          mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  shram_grant_ctrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_req_i  (host_req_i),
    .cpu_req_i   (cpu_req_i),
    .cpu_lock_i  (cpu_lock_i),
    .host_gnt_o  (host_gnt_o),
    .cpu_stall_o (cpu_stall_o),
    .cpu_beat_o  (cpu_beat)
  );

  shram_port_mux #(.AW(AW), .DW(DW), .FLAG_EN(FLAG_EN), .FLAG_ADDR(FLAG_ADDR)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_gnt_i   (host_gnt_o),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rd_i    (host_rd_i),
    .host_wr_i    (host_wr_i),
    .cpu_beat_i   (cpu_beat),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .mem_we_o     (mem_we),
    .mem_re_o     (mem_re),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .flag_o       (flag_o)
  );

  shram_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign host_rdata_o = mem_rdata;
  assign cpu_rdata_o  = mem_rdata;
endmodule

// File: tb/shram_arbiter_tb_top.sv
module shram_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        host_req = 0, host_rd = 0, host_wr = 0;
  logic [7:0]  host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic        cpu_req = 0, cpu_we = 0, cpu_lock = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        host_gnt, cpu_stall, flag;
  logic [15:0] host_rdata, cpu_rdata;

  shram_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_gnt_o(host_gnt), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_rdata_o(host_rdata),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_lock_i(cpu_lock),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_stall_o(cpu_stall),
    .cpu_rdata_o(cpu_rdata), .flag_o(flag)
  );

  int total = 0, bad = 0;
  logic [15:0] ref_mem [256];
  logic seen_gnt, seen_stall, accepted;
  int req_wait = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: called at a falling edge with inputs already driven
  task automatic tick();
    logic rd_pend;
    logic [15:0] rd_exp;
    rd_pend = 0; rd_exp = 0;
    #1;
    seen_gnt = host_gnt; seen_stall = cpu_stall;
    accepted = cpu_req && !cpu_stall;
    if (!host_req) begin
      chk("R4 gnt low on release", {31'b0, host_gnt}, 0);
      chk("R4 stall low on release", {31'b0, cpu_stall}, 0);
      req_wait = 0;
    end else if (!host_gnt) begin
      req_wait++;
      if (req_wait > 4) chk("R3 grant latency bound", req_wait, 4);
    end
    if (host_gnt) begin
      chk("R5 stalled under grant", {31'b0, cpu_stall}, 1);
      if (host_rd) begin rd_pend = 1; rd_exp = ref_mem[host_addr]; end
      if (host_wr) ref_mem[host_addr] = host_wdata;
    end else if (accepted) begin
      if (cpu_we) ref_mem[cpu_addr] = cpu_wdata;
      else begin rd_pend = 1; rd_exp = ref_mem[cpu_addr]; end
    end
    @(posedge clk);
    @(negedge clk);
    if (rd_pend) begin
      chk("R6 R8 read data", {16'b0, cpu_rdata}, {16'b0, rd_exp});
      chk("R6 host read data", {16'b0, host_rdata}, {16'b0, rd_exp});
    end
    chk("R9 flag mirrors mailbox", {31'b0, flag}, {31'b0, ref_mem[255] != 16'h0});
  endtask

  task automatic idle_all();
    host_req = 0; host_rd = 0; host_wr = 0;
    cpu_req = 0; cpu_we = 0; cpu_lock = 0;
  endtask

  task automatic cpu_read(input logic [7:0] a);
    cpu_req = 1; cpu_we = 0; cpu_lock = 0; cpu_addr = a;
    tick();
    cpu_req = 0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t, gnt_at, idx, beats;
    logic [15:0] v;
    int hold;
    for (int i = 0; i < 256; i++) ref_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 gnt", {31'b0, host_gnt}, 0);
    chk("R1 stall", {31'b0, cpu_stall}, 0);
    chk("R1 flag", {31'b0, flag}, 0);
    chk("R1 rdata", {16'b0, cpu_rdata}, 0);
    cpu_read(8'd77);
    chk("R1 ram zero", {16'b0, cpu_rdata}, 0);

    // R2 idle grant after one cycle
    host_req = 1;
    tick();
    chk("R2 no grant first cycle", {31'b0, seen_gnt}, 0);
    chk("R2 stall first cycle", {31'b0, seen_stall}, 1);
    tick();
    chk("R2 grant second cycle", {31'b0, seen_gnt}, 1);

    // R6 host write then read
    host_wr = 1; host_addr = 8'd5; host_wdata = 16'h1234;
    tick();
    host_wr = 0; host_rd = 1;
    tick();
    chk("R6 host readback", {16'b0, host_rdata}, 32'h1234);
    host_rd = 0;
    // R4 release and regain in same cycle
    host_req = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'd5;
    tick();
    chk("R4 beat taken on release", {31'b0, accepted}, 1);
    chk("R4 R8 cpu sees host data", {16'b0, cpu_rdata}, 32'h1234);
    cpu_req = 0;

    // R7 strobes without grant
    host_wr = 1; host_addr = 8'd5; host_wdata = 16'hFFFF;
    tick();
    host_wr = 0;
    cpu_read(8'd5);
    chk("R7 ungranted write ignored", {16'b0, cpu_rdata}, 32'h1234);

    // R3 R5 locked burst with forced stall and resume
    idx = 0; gnt_at = -1; t = 0; beats = 0;
    while (idx < 8 && t < 40) begin
      host_req = (t >= 1 && t < 8);
      cpu_req = 1; cpu_we = 1; cpu_addr = 8'(16 + idx);
      cpu_wdata = 16'hA000 + 16'(idx); cpu_lock = (idx < 7);
      tick();
      if (seen_gnt && gnt_at < 0) gnt_at = t;
      if (accepted) begin idx++; beats++; end
      t++;
    end
    idle_all();
    chk("R3 locked grant latency", gnt_at, 5);
    chk("R5 beat count", beats, 8);
    for (int k = 0; k < 8; k++) begin
      cpu_read(8'(16 + k));
      chk("R5 burst word", {16'b0, cpu_rdata}, 32'hA000 + k);
    end

    // R3 lock ending early gives latency 2
    cpu_req = 1; cpu_we = 1; cpu_lock = 1; cpu_addr = 8'd30; cpu_wdata = 16'h0030;
    tick();
    host_req = 1; cpu_lock = 0; cpu_addr = 8'd31; cpu_wdata = 16'h0031;
    tick();
    chk("R3 last locked beat taken", {31'b0, accepted}, 1);
    cpu_req = 0;
    tick();
    chk("R3 no grant yet", {31'b0, seen_gnt}, 0);
    tick();
    chk("R3 grant after group end", {31'b0, seen_gnt}, 1);

    // R10 re-request after one released edge
    host_req = 0;
    tick();
    host_req = 1;
    tick();
    chk("R10 new request not granted at once", {31'b0, seen_gnt}, 0);
    tick();
    chk("R10 new request granted", {31'b0, seen_gnt}, 1);

    // R9 mailbox from host then cleared by cpu
    host_wr = 1; host_addr = 8'd255; host_wdata = 16'h0001;
    tick();
    chk("R9 flag set by host", {31'b0, flag}, 1);
    host_wr = 0; host_req = 0;
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'd255; cpu_wdata = 16'h0;
    tick();
    chk("R9 flag cleared by cpu", {31'b0, flag}, 0);
    idle_all();
    tick();

    // random mixed traffic
    void'($urandom(32'h5EED));
    hold = 0;
    for (int n = 0; n < 3000; n++) begin
      if (!host_req) begin
        host_rd = 0;
        host_wr = ($urandom % 16 == 0);
        host_addr = 8'($urandom % 16); host_wdata = 16'($urandom);
        if ($urandom % 20 == 0) begin host_req = 1; hold = 2 + $urandom % 10; end
      end else if (seen_gnt) begin
        v = 16'($urandom);
        host_wr = v[0]; host_rd = !v[0] && v[1];
        host_addr = v[2] ? 8'd255 : 8'(v[7:4]); host_wdata = 16'($urandom % 4);
        if (hold == 0) begin host_req = 0; host_rd = 0; host_wr = 0; end
        else hold--;
      end else begin
        host_rd = 0; host_wr = 0;
      end
      if (!cpu_req || accepted) begin
        cpu_req = ($urandom % 10) < 7;
        cpu_we = $urandom % 2; cpu_lock = ($urandom % 4 == 0);
        cpu_addr = ($urandom % 32 == 0) ? 8'd255 : 8'($urandom % 16);
        cpu_wdata = 16'($urandom);
      end
      tick();
    end
    idle_all();
    for (int k = 0; k < 16; k++) begin
      cpu_read(8'(k));
      chk("R5 R6 R8 final ram match", {16'b0, cpu_rdata}, {16'b0, ref_mem[k]});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule